// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block sits between a CPU load/store port and a slower word-wide memory. It holds 2048 lines of one 32-bit word each, 8 KB in all, selected directly by the word address. Reads of a byte, a halfword or a word that fall inside a fixed cacheable window are answered from the line store when the tag matches. When the tag does not match, the aligned word is fetched from memory, written into the line, and the requested part of it is returned. In big-endian mode the byte offset is flipped before the lanes are picked.

Every store goes to memory, whatever the cache holds. A full-word store inside the window also writes the line. A byte or halfword store inside the window marks the line empty, so a partial word is never merged into the cache. A line is marked empty by a reserved tag code rather than by a separate valid flag. Requests outside the window go to memory and leave both the line store and the counters alone. The CPU side uses a ready/response handshake. The memory side holds a request until the memory acknowledges it. Counters of cacheable read hits and misses are brought out as status.

Top module: `wt_word_cache`

## Requirements
- R1: After reset cpuReady is 1, memReq is 0, both counters are 0, and every line is empty, so the first cacheable read of any address misses.
- R2: A request is cacheable only when (cpuAddr & 0xEFC00000) == 0. Any other request goes to memory, leaves the counters unchanged and returns the memory's data.
- R3: The line index is cpuAddr[12:2] and the tag compares cpuAddr[28] and cpuAddr[21:13]. Two addresses with the same index and different tags evict each other.
- R4: A cacheable read miss issues a memory read (memWe=0) of the word at the address with bits 1:0 cleared, stores the returned word in the line, and answers once memAck arrives.
- R5: A cacheable read hit raises cpuRspValid in the cycle after the request is accepted and issues no memory request.
- R6: cpuSize encodes 0 as byte, 1 as halfword and 2 as word. With bigEndian=0 and offset o = cpuAddr[1:0], a halfword read returns (word >> 8*(o&2)) & 0xFFFF and a byte read returns (word >> 8*o) & 0xFF.
- R7: With bigEndian=1 the offset used in R6 and R8 is cpuAddr[1:0] XOR 3.
- R8: Every write, hit or miss, cacheable or not, is sent to memory with memWe=1 and memAddr = word-aligned address. memBe is 1111 for a word, 0011 or 1100 for a halfword when the lane offset bit 1 is 0 or 1, and 1<<offset for a byte. The data is replicated across the lanes.
- R9: A cacheable word write stores the written word in the line, so the next read of that address hits and returns it.
- R10: A cacheable byte or halfword write marks the line empty, so the next read of that line misses and returns the merged memory contents.
- R11: The empty code never equals a legal tag. The first read of an address whose tag bits 21:13 are all ones misses, with cpuAddr[28] either 0 or 1.
- R12: hitCount and missCount each count cacheable reads only, and at most one of them steps per request.
- R13: While a memory access is outstanding cpuReady is 0, and memReq and memAddr stay stable until memAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bigEndian | input | 1 | Selects big-endian lane order |
| cpuReq | input | 1 | CPU request; accepted when cpuReady is 1 |
| cpuWe | input | 1 | 1 for a write, 0 for a read |
| cpuSize | input | 2 | 0 byte, 1 halfword, 2 word |
| cpuAddr | input | 32 | Byte address |
| cpuWData | input | 32 | Write data, right-aligned |
| cpuReady | output | 1 | Block can accept a request |
| cpuRspValid | output | 1 | One-cycle pulse when a request completes |
| cpuRData | output | 32 | Read result, right-aligned, zero-extended |
| memReq | output | 1 | Memory access pending |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Word-aligned memory address |
| memBe | output | 4 | Byte enables for writes |
| memWData | output | 32 | Write data, replicated across lanes |
| memAck | input | 1 | Memory completes the access |
| memRData | input | 32 | Memory read word, valid with memAck |
| hitCount | output | 16 | Cacheable read hits |
| missCount | output | 16 | Cacheable read misses |

## Verification
The cases hardest to reach from the ports are an address whose tag bits equal the all-ones pattern of a too-narrow empty code, and an address that differs from a cached one only in bit 28. Neither comes up with ordinary traffic. The stimulus therefore reads 0x003FE040 and 0x103FE080 into untouched lines and then reads the same index with bit 28 flipped. A partial store into a cached line is checked by following it with a word read that must miss and return memory's merged bytes. The lane sweep covers every aligned offset of every size in both byte orders.

// File: rtl/wc_pkg.sv
`timescale 1ns/1ps
package wc_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } sizeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;    // capture the request
    logic hitRsp;    // answer from the line store
    logic memDone;   // memory finished: answer and update line
    logic countHit;
    logic countMiss;
  } strobeT;
endpackage

// File: rtl/wc_lane.sv
`timescale 1ns/1ps
module wc_lane
  import wc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        offset,
  input  logic [1:0]        size,
  input  logic              bigEndian,
  output logic [WORD_W-1:0] value
);
  logic [1:0] laneOff;
  assign laneOff = bigEndian ? (offset ^ 2'b11) : offset;

  always_comb begin
    case (sizeT'(size))
      SZ_BYTE: value = (word >> {laneOff, 3'b000}) & 32'h0000_00FF;
      SZ_HALF: value = (word >> {laneOff[1], 4'b0000}) & 32'h0000_FFFF;
      default: value = word;
    endcase
  end
endmodule

// File: rtl/wc_ctrl.sv
`timescale 1ns/1ps
module wc_ctrl
  import wc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cpuReq,
  input  logic   cpuWe,
  input  logic   lookupHit,
  input  logic   lookupCacheable,
  input  logic   memAck,
  output logic   cpuReady,
  output logic   memReq,
  output strobeT stb
);
  typedef enum logic {ST_IDLE, ST_MEM} stateT;
  stateT state, stateNext;

  logic cacheRead;
  assign cacheRead = cpuReq && (state == ST_IDLE) && !cpuWe && lookupCacheable;

  always_comb begin
    stb           = '0;
    stb.accept    = (state == ST_IDLE) && cpuReq;
    stb.hitRsp    = cacheRead && lookupHit;
    stb.countHit  = cacheRead && lookupHit;
    stb.countMiss = cacheRead && !lookupHit;
    stb.memDone   = (state == ST_MEM) && memAck;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (stb.accept && !stb.hitRsp) stateNext = ST_MEM;
      ST_MEM:  if (memAck) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cpuReady = (state == ST_IDLE);
  assign memReq   = (state == ST_MEM);
endmodule

// File: rtl/wc_datapath.sv
`timescale 1ns/1ps
module wc_datapath
  import wc_pkg::*;
#(
  parameter int          INDEX_W    = 11,
  parameter int          TAG_LOW_W  = 9,
  parameter int          WIN_BIT    = 28,
  parameter int          COUNT_W    = 16,
  parameter logic [31:0] CACHE_MASK = 32'hEFC0_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic               bigEndian,
  input  logic               cpuWe,
  input  logic [1:0]         cpuSize,
  input  logic [31:0]        cpuAddr,
  input  logic [WORD_W-1:0]  cpuWData,
  input  logic [WORD_W-1:0]  memRData,
  output logic               lookupHit,
  output logic               lookupCacheable,
  output logic               memWe,
  output logic [31:0]        memAddr,
  output logic [3:0]         memBe,
  output logic [WORD_W-1:0]  memWData,
  output logic               cpuRspValid,
  output logic [WORD_W-1:0]  cpuRData,
  output logic [COUNT_W-1:0] hitCount,
  output logic [COUNT_W-1:0] missCount
);
  localparam int LINES   = 1 << INDEX_W;
  localparam int TAG_LSB = INDEX_W + 2;
  localparam int TAG_W   = TAG_LOW_W + 2;   // spare top bit keeps the empty code out of reach
  localparam logic [TAG_W-1:0] TAG_EMPTY = '1;

  function automatic logic [TAG_W-1:0] tagOf(input logic [31:0] a);
    return {1'b0, a[WIN_BIT], a[TAG_LSB+TAG_LOW_W-1:TAG_LSB]};
  endfunction

  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [WORD_W-1:0] dataArr [LINES];

  logic [31:0]       reqAddr;
  logic [1:0]        reqSize;
  logic              reqWe;
  logic              reqCacheable;
  logic [WORD_W-1:0] reqWData;

  logic [INDEX_W-1:0] lookIdx, reqIdx;
  assign lookIdx = cpuAddr[INDEX_W+1:2];
  assign reqIdx  = reqAddr[INDEX_W+1:2];

  assign lookupCacheable = (cpuAddr & CACHE_MASK) == 32'h0;
  assign lookupHit       = tagArr[lookIdx] == tagOf(cpuAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr      <= '0;
      reqSize      <= '0;
      reqWe        <= 1'b0;
      reqCacheable <= 1'b0;
      reqWData     <= '0;
    end else if (stb.accept) begin
      reqAddr      <= cpuAddr;
      reqSize      <= cpuSize;
      reqWe        <= cpuWe;
      reqCacheable <= lookupCacheable;
      reqWData     <= cpuWData;
    end
  end

  // Tag store: reset to the empty code, updated when memory completes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) tagArr[i] <= TAG_EMPTY;
    end else if (stb.memDone && reqCacheable) begin
      if (!reqWe || sizeT'(reqSize) == SZ_WORD) tagArr[reqIdx] <= tagOf(reqAddr);
      else                                      tagArr[reqIdx] <= TAG_EMPTY;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.memDone && reqCacheable) begin
      if (!reqWe)                             dataArr[reqIdx] <= memRData;
      else if (sizeT'(reqSize) == SZ_WORD)    dataArr[reqIdx] <= reqWData;
    end
  end

  // Memory side
  logic [1:0] wrOff;
  assign wrOff   = bigEndian ? (reqAddr[1:0] ^ 2'b11) : reqAddr[1:0];
  assign memAddr = {reqAddr[31:2], 2'b00};
  assign memWe   = reqWe;

  always_comb begin
    case (sizeT'(reqSize))
      SZ_BYTE: begin
        memBe    = 4'b0001 << wrOff;
        memWData = {4{reqWData[7:0]}};
      end
      SZ_HALF: begin
        memBe    = wrOff[1] ? 4'b1100 : 4'b0011;
        memWData = {2{reqWData[15:0]}};
      end
      default: begin
        memBe    = 4'b1111;
        memWData = reqWData;
      end
    endcase
  end

  // Read lane selection, shared by hit and fill paths
  logic [WORD_W-1:0] srcWord, laneVal;
  logic [1:0]        srcOff, srcSize;
  assign srcWord = stb.memDone ? memRData      : dataArr[lookIdx];
  assign srcOff  = stb.memDone ? reqAddr[1:0]  : cpuAddr[1:0];
  assign srcSize = stb.memDone ? reqSize       : cpuSize;

  wc_lane u_lane (
    .word     (srcWord),
    .offset   (srcOff),
    .size     (srcSize),
    .bigEndian(bigEndian),
    .value    (laneVal)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRspValid <= 1'b0;
      cpuRData    <= '0;
      hitCount    <= '0;
      missCount   <= '0;
    end else begin
      cpuRspValid <= stb.hitRsp || stb.memDone;
      if (stb.hitRsp || (stb.memDone && !reqWe)) cpuRData <= laneVal;
      else if (stb.memDone)                      cpuRData <= '0;
      if (stb.countHit)  hitCount  <= hitCount + 1'b1;
      if (stb.countMiss) missCount <= missCount + 1'b1;
    end
  end
endmodule

// File: rtl/wt_word_cache.sv
`timescale 1ns/1ps
module wt_word_cache
  import wc_pkg::*;
#(
  parameter int          INDEX_W    = 11,
  parameter int          TAG_LOW_W  = 9,
  parameter int          WIN_BIT    = 28,
  parameter int          COUNT_W    = 16,
  parameter logic [31:0] CACHE_MASK = 32'hEFC0_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bigEndian,
  input  logic               cpuReq,
  input  logic               cpuWe,
  input  logic [1:0]         cpuSize,
  input  logic [31:0]        cpuAddr,
  input  logic [31:0]        cpuWData,
  output logic               cpuReady,
  output logic               cpuRspValid,
  output logic [31:0]        cpuRData,
  output logic               memReq,
  output logic               memWe,
  output logic [31:0]        memAddr,
  output logic [3:0]         memBe,
  output logic [31:0]        memWData,
  input  logic               memAck,
  input  logic [31:0]        memRData,
  output logic [COUNT_W-1:0] hitCount,
  output logic [COUNT_W-1:0] missCount
);
  strobeT stb;
  logic   lookupHit, lookupCacheable;

  wc_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .cpuReq         (cpuReq),
    .cpuWe          (cpuWe),
    .lookupHit      (lookupHit),
    .lookupCacheable(lookupCacheable),
    .memAck         (memAck),
    .cpuReady       (cpuReady),
    .memReq         (memReq),
    .stb            (stb)
  );

  wc_datapath #(
    .INDEX_W   (INDEX_W),
    .TAG_LOW_W (TAG_LOW_W),
    .WIN_BIT   (WIN_BIT),
    .COUNT_W   (COUNT_W),
    .CACHE_MASK(CACHE_MASK)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .bigEndian      (bigEndian),
    .cpuWe          (cpuWe),
    .cpuSize        (cpuSize),
    .cpuAddr        (cpuAddr),
    .cpuWData       (cpuWData),
    .memRData       (memRData),
    .lookupHit      (lookupHit),
    .lookupCacheable(lookupCacheable),
    .memWe          (memWe),
    .memAddr        (memAddr),
    .memBe          (memBe),
    .memWData       (memWData),
    .cpuRspValid    (cpuRspValid),
    .cpuRData       (cpuRData),
    .hitCount       (hitCount),
    .missCount      (missCount)
  );
endmodule

// File: rtl/wt_word_cache_chk.sv
`timescale 1ns/1ps
module wt_word_cache_chk #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               cpuReq,
  input logic               cpuWe,
  input logic               cpuReady,
  input logic               cpuRspValid,
  input logic               memReq,
  input logic               memWe,
  input logic [31:0]        memAddr,
  input logic               memAck,
  input logic [COUNT_W-1:0] hitCount,
  input logic [COUNT_W-1:0] missCount
);
  // R13
  stall_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cpuReady);

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr));

  // R8
  write_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && cpuReady && cpuWe |=> memReq && memWe);

  // R5
  hit_quick_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitCount != $past(hitCount) |-> cpuRspValid && !memReq);

  // R4
  miss_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    missCount != $past(missCount) |-> memReq && !memWe);

  // R12
  single_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({hitCount != $past(hitCount), missCount != $past(missCount)}) <= 1);
endmodule

bind wt_word_cache wt_word_cache_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cpuReq     (cpuReq),
  .cpuWe      (cpuWe),
  .cpuReady   (cpuReady),
  .cpuRspValid(cpuRspValid),
  .memReq     (memReq),
  .memWe      (memWe),
  .memAddr    (memAddr),
  .memAck     (memAck),
  .hitCount   (hitCount),
  .missCount  (missCount)
);

// File: tb/wt_word_cache_bench.sv
`timescale 1ns/1ps
module wt_word_cache_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bigEndian = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [1:0]  cpuSize = 2'd0;
  logic [31:0] cpuAddr = '0;
  logic [31:0] cpuWData = '0;
  logic        cpuReady, cpuRspValid;
  logic [31:0] cpuRData;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWData;
  logic [3:0]  memBe;
  logic        memAck;
  logic [31:0] memRData;
  logic [15:0] hitCount, missCount;

  always #2.5 clk = ~clk;

  wt_word_cache u_wt_word_cache (.*);

  // Memory model: 4096 words, index {a[28], a[15:13], a[9:2]}
  logic [31:0] model [4096];
  int          waitCnt, memOps;
  logic [31:0] lastRdAddr, lastWrAddr, lastWrData;
  logic [3:0]  lastWrBe;

  function automatic logic [11:0] mIdx(input logic [31:0] a);
    return {a[28], a[15:13], a[9:2]};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4096; i++)
        model[i] <= {i[11:0], 4'h0, ~i[7:0], i[7:0]};
      memAck <= 1'b0; memRData <= '0; waitCnt <= 0; memOps <= 0;
      lastRdAddr <= '0; lastWrAddr <= '0; lastWrData <= '0; lastWrBe <= '0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck) begin
        if (waitCnt == 2) begin
          waitCnt <= 0;
          memAck  <= 1'b1;
          memOps  <= memOps + 1;
          if (memWe) begin
            lastWrAddr <= memAddr; lastWrData <= memWData; lastWrBe <= memBe;
            for (int b = 0; b < 4; b++)
              if (memBe[b]) model[mIdx(memAddr)][8*b +: 8] <= memWData[8*b +: 8];
          end else begin
            lastRdAddr <= memAddr;
            memRData   <= model[mIdx(memAddr)];
          end
        end else waitCnt <= waitCnt + 1;
      end
    end
  end

  int nChk = 0, nFail = 0, stallBad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refLane(input logic [31:0] w, input logic [1:0] off,
                                          input logic [1:0] sz, input logic be);
    int o;
    o = be ? int'(off ^ 2'b11) : int'(off);
    if (sz == 2'd0) return (w >> (8*o)) & 32'hFF;
    if (sz == 2'd1) return (w >> (8*(o & 2))) & 32'hFFFF;
    return w;
  endfunction

  task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
    while (!cpuReady) @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuSize = sz; cpuAddr = a; cpuWData = wd;
    @(negedge clk);
    cpuReq = 1'b0;
    lat = 1;
    while (!cpuRspValid && lat < 50) begin
      if (memReq && cpuReady) stallBad++;
      @(negedge clk);
      lat++;
    end
    rd = cpuRData;
  endtask

  task automatic readChk(input string tag, input logic [1:0] sz, input logic [31:0] a);
    logic [31:0] rd; int lat;
    access(1'b0, sz, a, 32'h0, rd, lat);
    chk(tag, rd, refLane(model[mIdx(a)], a[1:0], sz, bigEndian));
  endtask

  initial begin
    logic [31:0] rd;
    int lat, h0, m0, ops0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", {31'b0, cpuReady}, 32'd1);
    chk("R1 memReq", {31'b0, memReq}, 32'd0);
    chk("R1 counters", {hitCount, missCount}, 32'd0);

    // R4 first read misses, aligned fetch
    access(1'b0, 2'd2, 32'h0000_0100, 0, rd, lat);
    chk("R4 miss data", rd, model[mIdx(32'h100)]);
    chk("R1 first read misses", {16'b0, missCount}, 32'd1);
    chk("R4 aligned fetch", lastRdAddr, 32'h0000_0100);
    chk("R13 stall", stallBad, 0);
    // R5 hit
    ops0 = memOps;
    access(1'b0, 2'd2, 32'h0000_0100, 0, rd, lat);
    chk("R5 hit latency", lat, 1);
    chk("R5 no memory op", memOps, ops0);
    chk("R5 hit data", rd, model[mIdx(32'h100)]);
    chk("R12 hit count", {16'b0, hitCount}, 32'd1);
    // R4 byte miss fetches the aligned word
    access(1'b0, 2'd0, 32'h0000_0143, 0, rd, lat);
    chk("R4 aligned fetch of byte", lastRdAddr, 32'h0000_0140);

    // R6 / R7 sweep of every aligned offset in both byte orders
    h0 = hitCount; m0 = missCount;
    for (int be = 0; be < 2; be++) begin
      bigEndian = be[0];
      for (int w = 0; w < 4; w++)
        for (int sz = 0; sz < 3; sz++)
          for (int off = 0; off < 4; off++)
            if ((sz == 1 && off[0]) || (sz == 2 && off != 0)) ;
            else readChk(be ? "R7 big-endian lane" : "R6 little-endian lane",
                         sz[1:0], 32'h0000_0200 + 32'(be*16 + w*4 + off));
    end
    chk("R12 sweep misses", {16'b0, missCount} - m0, 32'd8);
    chk("R12 sweep hits", {16'b0, hitCount} - h0, 32'd48);
    bigEndian = 1'b0;

    // R2 bypass
    h0 = hitCount; m0 = missCount; ops0 = memOps;
    readChk("R2 bypass data", 2'd2, 32'h2000_0F00);
    readChk("R2 bypass data", 2'd1, 32'h0100_0F02);
    chk("R2 counters unchanged", {hitCount, missCount}, {h0[15:0], m0[15:0]});
    chk("R2 memory used", memOps, ops0 + 2);
    m0 = missCount;
    readChk("R2 bit28 cacheable", 2'd2, 32'h1000_0180);
    chk("R2 bit28 counted", {16'b0, missCount} - m0, 32'd1);

    // R3 conflict eviction
    m0 = missCount;
    readChk("R3 conflict", 2'd2, 32'h0000_0300);
    readChk("R3 conflict", 2'd2, 32'h0000_2300);
    readChk("R3 conflict", 2'd2, 32'h0000_0300);
    chk("R3 evictions miss", {16'b0, missCount} - m0, 32'd3);
    h0 = hitCount;
    readChk("R3 rehit", 2'd2, 32'h0000_0300);
    chk("R3 rehit counted", {16'b0, hitCount} - h0, 32'd1);

    // R11 all-ones tag bits never match the empty code
    m0 = missCount;
    readChk("R11 tag 1FF", 2'd2, 32'h003F_E040);
    readChk("R11 tag bit28", 2'd2, 32'h103F_E080);
    chk("R11 first reads miss", {16'b0, missCount} - m0, 32'd2);
    m0 = missCount;
    readChk("R3 bit28 differs", 2'd2, 32'h103F_E040);
    chk("R3 bit28 in tag", {16'b0, missCount} - m0, 32'd1);

    // R9 word write updates the line
    access(1'b1, 2'd2, 32'h0000_0100, 32'hDEAD_BEEF, rd, lat);
    chk("R8 word be", {28'b0, lastWrBe}, 32'hF);
    chk("R8 word addr", lastWrAddr, 32'h0000_0100);
    ops0 = memOps;
    access(1'b0, 2'd2, 32'h0000_0100, 0, rd, lat);
    chk("R9 hit after word write", lat, 1);
    chk("R9 written data", rd, 32'hDEAD_BEEF);
    chk("R9 no fetch", memOps, ops0);

    // R10 byte write invalidates
    access(1'b1, 2'd0, 32'h0000_0101, 32'h0000_005A, rd, lat);
    chk("R8 byte be", {28'b0, lastWrBe}, 32'b0010);
    chk("R8 byte data", lastWrData, 32'h5A5A_5A5A);
    m0 = missCount;
    access(1'b0, 2'd2, 32'h0000_0100, 0, rd, lat);
    chk("R10 miss after byte write", {16'b0, missCount} - m0, 32'd1);
    chk("R10 merged data", rd, 32'hDEAD_5AEF);

    // R10 / R7 halfword write in big-endian order
    bigEndian = 1'b1;
    access(1'b1, 2'd1, 32'h0000_0202, 32'h0000_C0DE, rd, lat);
    chk("R7 half be", {28'b0, lastWrBe}, 32'b0011);
    chk("R8 half data", lastWrData, 32'hC0DE_C0DE);
    m0 = missCount;
    readChk("R10 half merged", 2'd1, 32'h0000_0202);
    chk("R10 miss after half write", {16'b0, missCount} - m0, 32'd1);
    bigEndian = 1'b0;

    // R8 bypass write still reaches memory
    h0 = hitCount; m0 = missCount; ops0 = memOps;
    access(1'b1, 2'd2, 32'h2000_0F04, 32'h1234_5678, rd, lat);
    chk("R8 bypass write op", memOps, ops0 + 1);
    chk("R8 bypass write addr", lastWrAddr, 32'h2000_0F04);
    readChk("R8 bypass readback", 2'd2, 32'h2000_0F04);
    chk("R12 writes not counted", {hitCount, missCount}, {h0[15:0], m0[15:0]});
    chk("R13 no early ready", stallBad, 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule